// File: doc/BRIEF.md
# DMA Interrupt Coalescing Controller

This block sits beside one channel of a scatter-gather DMA engine and decides when the channel raises its interrupt line. The engine pulses an input each time it retires a list element and supplies that element's end-of-packet and request-interrupt flags. Only elements that carry both flags count as completion events. A programmable threshold groups these events, so that software is interrupted once per group instead of once per element. A separate DMA error pulse bypasses the grouping and is reported at once.

Software sees two 32-bit words through a plain select/write/read port. The control word holds the threshold and three enable bits. The status word holds two sticky pending flags, and writing a 1 to a flag clears it. The interrupt output is a level that stays high while the master enable is set and any pending flag is set.

The event counter is compared with the threshold before it is incremented. A threshold of N therefore gives one interrupt for every N+1 qualifying events. The counter is held at zero while the channel's DMA enable level is low. Events that remain in the counter when traffic stops are never reported.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset the control word reads 0x00000000, the status word reads 0x00000000 and `irq` is low.
- R2: The control word (reg_sel=0) holds the threshold in bits 23:16, the list-event enable in bit 2, the error enable in bit 1 and the master enable in bit 0. Bits 31:24 and 15:3 always read 0, and writes to them are ignored (writing 0xFFFFFFFF reads back 0x00FF0007).
- R3: A qualifying event is a cycle in which `elem_done`, `elem_eop` and `elem_irq` are all 1 while `dma_enable` and control bit 2 are 1. Any other element completion leaves the counter unchanged.
- R4: On a qualifying event, if the counter equals the threshold, the counter returns to 0 and status bit 0 sets on the following edge. Otherwise the counter increments. With threshold N, every (N+1)-th event interrupts, for N from 0 to 255.
- R5: While `dma_enable` is 0 the counter is held at 0, and list events are not counted.
- R6: Events left in the counter below the threshold raise no interrupt, however long the inputs stay idle.
- R7: A `dma_err` pulse while control bit 1 is 1 sets status bit 1 on the next edge, independent of the counter. When bit 1 is 0 the pulse is ignored.
- R8: Writing the status word (reg_sel=1) clears each pending bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A set arriving in the same cycle as its clear wins.
- R9: `irq` is high exactly when control bit 0 is 1 and status bit 0 or bit 1 is 1. The pending bits stay set while the master enable is 0.
- R10: If the threshold is lowered below the current count, the counter keeps incrementing through 255 and wraps to 0 before it can match. Starting from a count of 3, a threshold of 1 fires on the 255th subsequent event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Word select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| elem_done | input | 1 | Pulse: a list element completed |
| elem_eop | input | 1 | End-of-packet flag of the completing element |
| elem_irq | input | 1 | Interrupt-request flag of the completing element |
| dma_err | input | 1 | Pulse: DMA error |
| dma_enable | input | 1 | Channel DMA enable level |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default 8-bit counter. At this width every threshold is reachable in a few hundred cycles. Thresholds 0 through 31, plus 127 and 255, are swept with two full groups each, and the interrupt position after every event is compared with the arithmetic (k mod (N+1)). The full 8-bit width also makes the wrap-around case of a lowered threshold observable at the port, as the exact event count before the late match.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 8;
  localparam int THR_LSB    = 16;
  localparam int BIT_MASTER = 0;
  localparam int BIT_ERR_EN = 1;
  localparam int BIT_SGL_EN = 2;
  localparam int ST_SGL     = 0;
  localparam int ST_ERR     = 1;

  typedef struct packed {
    logic [CNT_W-1:0] thr;
    logic             sgl_en;
    logic             err_en;
    logic             master_en;
  } ctrl_t;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import dma_irq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic [DW-1:0] ctrl_word
);
  localparam int THR_MSB = THR_LSB + CNT_W - 1;

  ctrl_t ctrl_q, ctrl_d;

  // next-state: field decode of the write data
  always_comb begin
    ctrl_d           = ctrl_q;
    ctrl_d.thr       = wdata[THR_MSB:THR_LSB];
    ctrl_d.sgl_en    = wdata[BIT_SGL_EN];
    ctrl_d.err_en    = wdata[BIT_ERR_EN];
    ctrl_d.master_en = wdata[BIT_MASTER];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // read-back assembly; all other bit positions stay zero
  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[THR_MSB:THR_LSB]  = ctrl_q.thr;
    ctrl_word[BIT_SGL_EN]       = ctrl_q.sgl_en;
    ctrl_word[BIT_ERR_EN]       = ctrl_q.err_en;
    ctrl_word[BIT_MASTER]       = ctrl_q.master_en;
  end

  assign ctrl = ctrl_q;

  // R2: a write is reflected in the stored threshold on the next cycle
  a_r2_thr_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q.thr == $past(wdata[THR_MSB:THR_LSB]));
  // R2: without a write the control word holds
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_coalesce_counter.sv
module irq_coalesce_counter
  import dma_irq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_enable,
  input  logic          sgl_en,
  input  logic          evt_raw,
  input  logic [CW-1:0] thr,
  output logic          fire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual, hit, cnt_ce;

  assign qual   = evt_raw & sgl_en & dma_enable;
  assign hit    = (cnt_q == thr);
  assign fire   = qual & hit;
  assign cnt_ce = qual | ~dma_enable;

  always_comb begin
    cnt_d = cnt_q;
    if (!dma_enable)  cnt_d = '0;
    else if (qual)    cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R5: disabled channel leaves the counter at zero
  a_r5_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_enable |=> cnt_q == '0);
  // R3: non-qualifying cycles on an enabled channel do not move the counter
  a_r3_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_enable && !qual) |=> $stable(cnt_q));
  // R4: a match returns the counter to zero
  a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == '0);
  // R4 / R10: a miss steps by one, wrapping at the top
  a_r10_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !hit) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/irq_pending_status.sv
module irq_pending_status (
  input  logic clk,
  input  logic rst_n,
  input  logic sgl_set,
  input  logic err_set,
  input  logic sgl_clr,
  input  logic err_clr,
  input  logic master_en,
  output logic sgl_pend,
  output logic err_pend,
  output logic irq
);
  logic sgl_d, err_d, sgl_ce, err_ce;

  assign sgl_ce = sgl_set | sgl_clr;
  assign err_ce = err_set | err_clr;
  assign sgl_d  = sgl_set;   // set wins; otherwise a clear is pending
  assign err_d  = err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgl_pend <= 1'b0;
      err_pend <= 1'b0;
    end else begin
      if (sgl_ce) sgl_pend <= sgl_d;
      if (err_ce) err_pend <= err_d;
    end
  end

  assign irq = master_en & (sgl_pend | err_pend);

  // R8: a set in the clear cycle still leaves the bit set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_set || err_set) |=> (sgl_pend || err_pend));
  // R8: a lone clear removes the bit
  a_r8_w1c_sgl: assert property (@(posedge clk) disable iff (!rst_n)
    (sgl_clr && !sgl_set) |=> !sgl_pend);
  // R9: pending bits are sticky with no clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && !err_clr) |=> err_pend);
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
  import dma_irq_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          elem_done,
  input  logic          elem_eop,
  input  logic          elem_irq,
  input  logic          dma_err,
  input  logic          dma_enable,
  output logic          irq
);
  localparam int RSV_HI_LSB = THR_LSB + CW;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ctrl_t         ctrl;
  logic [DW-1:0] ctrl_word, stat_word;
  logic          wr_ctrl, wr_stat, fire, sgl_pend, err_pend;

  assign wr_ctrl = reg_wr & ~reg_sel;
  assign wr_stat = reg_wr &  reg_sel;

  irq_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_ctrl  (wr_ctrl),
    .wdata    (reg_wdata),
    .ctrl     (ctrl),
    .ctrl_word(ctrl_word)
  );

  irq_coalesce_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s2),
    .dma_enable(dma_enable),
    .sgl_en    (ctrl.sgl_en),
    .evt_raw   (elem_done & elem_eop & elem_irq),
    .thr       (ctrl.thr),
    .fire      (fire)
  );

  irq_pending_status u_pend (
    .clk      (clk),
    .rst_n    (rst_s2),
    .sgl_set  (fire),
    .err_set  (dma_err & ctrl.err_en),
    .sgl_clr  (wr_stat & reg_wdata[ST_SGL]),
    .err_clr  (wr_stat & reg_wdata[ST_ERR]),
    .master_en(ctrl.master_en),
    .sgl_pend (sgl_pend),
    .err_pend (err_pend),
    .irq      (irq)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[ST_SGL] = sgl_pend;
    stat_word[ST_ERR] = err_pend;
  end

  assign reg_rdata = reg_sel ? stat_word : ctrl_word;

  // R2: reserved bits of the control word never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_s2)
    !reg_sel |-> (reg_rdata[DW-1:RSV_HI_LSB] == '0 &&
                  reg_rdata[THR_LSB-1:BIT_SGL_EN+1] == '0));
  // R7: an enabled error pulse shows in the status word next cycle
  a_r7_err_direct: assert property (@(posedge clk) disable iff (!rst_s2)
    (dma_err && ctrl.err_en) |=> err_pend);
endmodule

// File: tb/dma_irq_coalescer_tb_top.sv
module dma_irq_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        elem_done, elem_eop, elem_irq, dma_err, dma_enable, irq;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  dma_irq_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .elem_done(elem_done),
    .elem_eop(elem_eop), .elem_irq(elem_irq), .dma_err(dma_err),
    .dma_enable(dma_enable), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic elem(input logic dn, input logic ep, input logic fl);
    elem_done = dn; elem_eop = ep; elem_irq = fl;
    @(negedge clk);
    elem_done = 1'b0; elem_eop = 1'b0; elem_irq = 1'b0;
  endtask

  task automatic err_pulse();
    dma_err = 1'b1;
    @(negedge clk);
    dma_err = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int thr, input logic [2:0] en);
    return {8'h00, thr[7:0], 13'h0, en};
  endfunction

  // program control word and flush the counter through dma_enable
  task automatic setup(input int thr);
    wr_reg(1'b0, ctl(thr, 3'b111));
    dma_enable = 1'b0;
    @(negedge clk);
    dma_enable = 1'b1;
    wr_reg(1'b1, 32'h3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    elem_done = 1'b0; elem_eop = 1'b0; elem_irq = 1'b0;
    dma_err = 1'b0; dma_enable = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(1'b0, rd); chk("R1 ctrl", rd, 32'h0);
    rd_reg(1'b1, rd); chk("R1 status", rd, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 field layout and reserved bits
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, rd); chk("R2 all ones", rd, 32'h00FF_0007);
    wr_reg(1'b0, 32'h1234_5678);
    rd_reg(1'b0, rd); chk("R2 pattern", rd, 32'h0034_0000);

    // R3 non-qualifying completions
    dma_enable = 1'b1;
    setup(0);
    elem(1, 0, 1); chk("R3 no eop", {31'b0, irq}, 32'h0);
    elem(1, 1, 0); chk("R3 no flag", {31'b0, irq}, 32'h0);
    elem(0, 1, 1); chk("R3 no done", {31'b0, irq}, 32'h0);
    elem(1, 1, 1); chk("R3 qualifying", {31'b0, irq}, 32'h1);
    wr_reg(1'b1, 32'h1);
    // R3 list enable off: event must not advance the counter
    setup(1);
    wr_reg(1'b0, ctl(1, 3'b011));
    elem(1, 1, 1); chk("R3 sgl_en off", {31'b0, irq}, 32'h0);
    wr_reg(1'b0, ctl(1, 3'b111));
    elem(1, 1, 1); chk("R3 first counted", {31'b0, irq}, 32'h0);
    elem(1, 1, 1); chk("R3 second counted", {31'b0, irq}, 32'h1);

    // R4 threshold sweep
    for (int t = 0; t < 34; t++) begin
      int thr;
      thr = (t < 32) ? t : ((t == 32) ? 127 : 255);
      setup(thr);
      for (int i = 1; i <= 2 * (thr + 1); i++) begin
        logic e;
        e = ((i % (thr + 1)) == 0);
        elem(1, 1, 1);
        chk($sformatf("R4 thr=%0d ev=%0d", thr, i), {31'b0, irq}, {31'b0, e});
        if (e) begin
          rd_reg(1'b1, rd); chk("R4 status", rd, 32'h1);
          wr_reg(1'b1, 32'h1);
          chk("R8 cleared", {31'b0, irq}, 32'h0);
        end
      end
    end

    // R5 counter held while disabled
    setup(3);
    elem(1, 1, 1); elem(1, 1, 1);
    dma_enable = 1'b0;
    elem(1, 1, 1); elem(1, 1, 1); elem(1, 1, 1);
    chk("R5 disabled", {31'b0, irq}, 32'h0);
    dma_enable = 1'b1;
    elem(1, 1, 1); elem(1, 1, 1); elem(1, 1, 1);
    chk("R5 three after", {31'b0, irq}, 32'h0);
    elem(1, 1, 1);
    chk("R5 fourth fires", {31'b0, irq}, 32'h1);

    // R6 leftover events
    setup(4);
    elem(1, 1, 1); elem(1, 1, 1); elem(1, 1, 1);
    repeat (50) @(negedge clk);
    chk("R6 no flush", {31'b0, irq}, 32'h0);

    // R7 error path
    wr_reg(1'b0, ctl(0, 3'b001));
    err_pulse();
    rd_reg(1'b1, rd); chk("R7 err disabled", rd, 32'h0);
    wr_reg(1'b0, ctl(0, 3'b011));
    err_pulse();
    rd_reg(1'b1, rd); chk("R7 err status", rd, 32'h2);
    chk("R7 err irq", {31'b0, irq}, 32'h1);

    // R8 write-one-to-clear
    wr_reg(1'b1, 32'h0);
    rd_reg(1'b1, rd); chk("R8 write zero", rd, 32'h2);
    setup(0);
    elem(1, 1, 1); err_pulse();
    wr_reg(1'b1, 32'h2);
    rd_reg(1'b1, rd); chk("R8 clear err only", rd, 32'h1);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h1;
    elem_done = 1'b1; elem_eop = 1'b1; elem_irq = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    elem_done = 1'b0; elem_eop = 1'b0; elem_irq = 1'b0;
    rd_reg(1'b1, rd); chk("R8 set wins", rd, 32'h1);
    wr_reg(1'b1, 32'h3);

    // R9 master gating
    wr_reg(1'b0, ctl(0, 3'b110));
    err_pulse();
    chk("R9 master off irq", {31'b0, irq}, 32'h0);
    rd_reg(1'b1, rd); chk("R9 pending kept", rd, 32'h2);
    wr_reg(1'b0, ctl(0, 3'b111));
    chk("R9 master on irq", {31'b0, irq}, 32'h1);
    wr_reg(1'b1, 32'h3);
    chk("R9 nothing pending", {31'b0, irq}, 32'h0);

    // R10 lowered threshold wraps
    setup(5);
    elem(1, 1, 1); elem(1, 1, 1); elem(1, 1, 1);
    wr_reg(1'b0, ctl(1, 3'b111));
    for (int k = 1; k <= 255; k++) begin
      elem(1, 1, 1);
      chk($sformatf("R10 ev=%0d", k), {31'b0, irq}, {31'b0, (k == 255)});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule